// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. Each cycle it takes the current accumulator value, a second operand and a 4-bit operation code. It produces the new accumulator value, a strobe that says whether that value should be written back, and the flag set the operation would leave behind. The result path is purely combinational. A five-bit flag register inside the block captures the new flags on a clock edge when the execute strobe is high.

The flags are sign, zero, auxiliary (nibble) carry, parity and carry. They feed the next operation, because carry and auxiliary carry are inputs to several operations. They also feed an eight-way condition tester that a sequencer uses to decide conditional branches. Operand fetch, memory access and instruction decoding stay outside the block.

Top module: `acc_alu`

## Requirements
- R1: Opcodes 0 (add) and 1 (add with carry) give result = acc + operand (+ stored carry for opcode 1) mod 256. CY is the carry out of bit 7. AC is the carry out of bit 3. S, Z and P follow the result.
- R2: Opcodes 2 (subtract) and 3 (subtract with borrow) give result = acc − operand (− stored carry for opcode 3) mod 256. CY is 1 when the true difference is negative. AC is 1 when the low-nibble difference borrows. S, Z and P follow the result.
- R3: Opcode 7 (compare) sets the flags exactly as opcode 2 would. It drives the difference on result with result_we low, so CY=1 when acc < operand and Z=1 when they are equal.
- R4: Opcodes 4 (AND), 5 (XOR) and 6 (OR) produce the bitwise result and clear CY. AND sets AC to 1, while XOR and OR clear AC. S, Z and P follow the result.
- R5: Opcode 13 inverts every accumulator bit and leaves all five flags unchanged.
- R6: Opcode 14 forces CY to 1 and opcode 15 inverts CY. Neither changes any other flag, result equals acc, and result_we is low.
- R7: Opcode 8 rotates left with bit 7 entering bit 0. Opcode 9 rotates right with bit 0 entering bit 7. In both cases the bit moved out is copied into CY and the other flags are unchanged.
- R8: Opcode 10 rotates left through carry (old CY enters bit 0, bit 7 goes to CY). Opcode 11 rotates right through carry (old CY enters bit 7, bit 0 goes to CY). Other flags are unchanged.
- R9: Opcode 12 (decimal adjust) first adds 06h when the low nibble exceeds 9 or AC is set, and AC becomes the carry out of bit 3 of that step. It then adds 60h when the stored CY is set, that step carried out of bit 7, or its high nibble exceeds 9. CY becomes 1 exactly when the 60h correction applied. S, Z and P follow the result.
- R10: The flags output packs S,Z,AC,P,CY in bits 4,3,2,1,0. It is 0 after a clock edge with rst_n low. It loads flags_next on an edge with exec_en high and holds on an edge with exec_en low.
- R11: cond_true tests the registered flags by cond_sel: 0 CY=0, 1 CY=1, 2 Z=0, 3 Z=1, 4 S=0, 5 S=1, 6 P=0, 7 P=1.
- R12: result_we is high for every opcode except 7, 14 and 15.
- R13: P is 1 when the result has an even number of one bits, S is bit 7 of the result, and Z is 1 when the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| exec_en | input | 1 | Load flags_next into the flag register at this edge |
| opcode | input | 4 | Operation select |
| acc_in | input | 8 | Current accumulator value |
| operand | input | 8 | Second operand |
| cond_sel | input | 3 | Branch condition select |
| result | output | 8 | New accumulator value |
| result_we | output | 1 | Result should be written to the accumulator |
| flags_next | output | 5 | Flags the operation produces ({S,Z,AC,P,CY}) |
| flags | output | 5 | Registered flags ({S,Z,AC,P,CY}) |
| cond_true | output | 1 | Selected condition holds on the registered flags |

## Verification
The block has no size knob. The bench builds it with the package values of an 8-bit datapath, 16 opcodes and a 3-bit condition select, which keeps every operand pair within reach. Each two-operand opcode is swept over all 65,536 accumulator/operand pairs, once with stored carry clear and twice with it set. Each one-operand opcode is swept over all 256 accumulator values in five flag states that combine CY and AC, which is where the decimal-adjust corrections and the through-carry rotates diverge. Every flag-register load is followed by a check of all eight branch conditions.

// File: rtl/acc_alu_pkg.sv
// Shared constants, opcode encoding and flag layout for the accumulator ALU.
// Assumes an 8-bit datapath split into two BCD nibbles.
package acc_alu_pkg;

    localparam int DATA_W   = 8;
    localparam int NIB_W    = DATA_W / 2;
    localparam int OP_W     = 4;
    localparam int SEL_W    = 3;
    localparam int FLAG_W   = 5;
    localparam int NUM_COND = 1 << SEL_W;
    localparam int NUM_TEST = NUM_COND / 2;

    localparam logic [NIB_W-1:0]  BCD_MAX = NIB_W'(9);
    localparam logic [DATA_W:0]   LO_ADJ  = (DATA_W+1)'(6);
    localparam logic [DATA_W-1:0] HI_ADJ  = DATA_W'(6) << NIB_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CMP = 4'd7,
        OP_RLC = 4'd8,
        OP_RRC = 4'd9,
        OP_RAL = 4'd10,
        OP_RAR = 4'd11,
        OP_DAA = 4'd12,
        OP_CMA = 4'd13,
        OP_STC = 4'd14,
        OP_CMC = 4'd15
    } op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    // Even-parity indicator: 1 when the vector holds an even count of ones.
    function automatic logic even_par(input logic [DATA_W-1:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
// Adder-based operations: add, add with carry, subtract, subtract with
// borrow, compare and decimal adjust. One shared 9-bit adder serves the
// binary forms; subtraction is done as acc + ~operand + ~borrow.
// Assumes op is one of the adder-class opcodes; for others output is don't-care.
module acc_alu_arith
    import acc_alu_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cy_in,
    input  logic              ac_in,
    output logic [DATA_W-1:0] res,
    output flags_t            flg
);

    logic              is_sub;
    logic              cin;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;
    logic              nib_c;
    logic              lo_fix;
    logic [DATA_W:0]   adj1;
    logic              hi_fix;
    logic [DATA_W-1:0] adj2;

    // Shared adder with operand inversion for the subtract forms.
    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        cin    = ((op == OP_ADC) || (op == OP_SBB)) & cy_in;
        b_eff  = is_sub ? ~b : b;
        sum    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, (is_sub ? ~cin : cin)};
        nib_c  = a[NIB_W] ^ b_eff[NIB_W] ^ sum[NIB_W];
    end

    // Two-step BCD correction after a binary add.
    always_comb begin
        lo_fix = (a[NIB_W-1:0] > BCD_MAX) | ac_in;
        adj1   = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
        hi_fix = cy_in | adj1[DATA_W] | (adj1[DATA_W-1:NIB_W] > BCD_MAX);
        adj2   = adj1[DATA_W-1:0] + (hi_fix ? HI_ADJ : '0);
    end

    // Result and flag selection for the adder class.
    always_comb begin
        if (op == OP_DAA) begin
            res    = adj2;
            flg.ac = a[NIB_W] ^ adj1[NIB_W];
            flg.cy = hi_fix;
        end else begin
            res    = sum[DATA_W-1:0];
            flg.ac = is_sub ? ~nib_c : nib_c;
            flg.cy = is_sub ? ~sum[DATA_W] : sum[DATA_W];
        end
        flg.s = res[DATA_W-1];
        flg.z = (res == '0);
        flg.p = even_par(res);
    end

endmodule

// File: rtl/acc_alu_logic.sv
// Bitwise, rotate, complement and carry-control operations.
// Assumes op is outside the adder class; such opcodes pass acc and flags through.
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  flags_t            f,
    output logic [DATA_W-1:0] res,
    output flags_t            flg
);

    logic upd_szp;

    // Per-opcode result and selective flag update.
    always_comb begin
        res     = a;
        flg     = f;
        upd_szp = 1'b0;
        case (op)
            OP_AND: begin
                res = a & b; upd_szp = 1'b1; flg.ac = 1'b1; flg.cy = 1'b0;
            end
            OP_XOR: begin
                res = a ^ b; upd_szp = 1'b1; flg.ac = 1'b0; flg.cy = 1'b0;
            end
            OP_OR: begin
                res = a | b; upd_szp = 1'b1; flg.ac = 1'b0; flg.cy = 1'b0;
            end
            OP_CMA: res = ~a;
            OP_STC: flg.cy = 1'b1;
            OP_CMC: flg.cy = ~f.cy;
            OP_RLC: begin
                res = {a[DATA_W-2:0], a[DATA_W-1]}; flg.cy = a[DATA_W-1];
            end
            OP_RRC: begin
                res = {a[0], a[DATA_W-1:1]}; flg.cy = a[0];
            end
            OP_RAL: begin
                res = {a[DATA_W-2:0], f.cy}; flg.cy = a[DATA_W-1];
            end
            OP_RAR: begin
                res = {f.cy, a[DATA_W-1:1]}; flg.cy = a[0];
            end
            default: ;
        endcase
        if (upd_szp) begin
            flg.s = res[DATA_W-1];
            flg.z = (res == '0);
            flg.p = even_par(res);
        end
    end

endmodule

// File: rtl/acc_alu_cond.sv
// Eight-way branch condition tester. Each tested flag yields a
// "clear" test at an even select and a "set" test at the next odd one.
// Assumes tested = {P, S, Z, CY}, ordered by ascending select pair.
module acc_alu_cond
    import acc_alu_pkg::*;
(
    input  logic [NUM_TEST-1:0] tested,
    input  logic [SEL_W-1:0]    sel,
    output logic                hit
);

    logic [NUM_COND-1:0] tests;

    for (genvar i = 0; i < NUM_TEST; i++) begin : g_pair
        assign tests[2*i]   = ~tested[i];
        assign tests[2*i+1] =  tested[i];
    end

    // Pick the requested test.
    always_comb hit = tests[sel];

endmodule

// File: rtl/acc_alu.sv
// Accumulator ALU top: routes the opcode to the adder or logic unit,
// raises the write strobe, holds the flag register and tests branch
// conditions on it. Assumes the caller drives acc_in/operand stable
// around any edge where exec_en is high.
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] operand,
    input  logic [SEL_W-1:0]  cond_sel,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [FLAG_W-1:0] flags_next,
    output logic [FLAG_W-1:0] flags,
    output logic              cond_true
);

    op_e               op;
    flags_t            flags_q;
    flags_t            ar_flg;
    flags_t            lg_flg;
    flags_t            nx_flg;
    logic [DATA_W-1:0] ar_res;
    logic [DATA_W-1:0] lg_res;
    logic              adder_class;

    assign op = op_e'(opcode);

    acc_alu_arith u_arith (
        .op    (op),
        .a     (acc_in),
        .b     (operand),
        .cy_in (flags_q.cy),
        .ac_in (flags_q.ac),
        .res   (ar_res),
        .flg   (ar_flg)
    );

    acc_alu_logic u_logic (
        .op  (op),
        .a   (acc_in),
        .b   (operand),
        .f   (flags_q),
        .res (lg_res),
        .flg (lg_flg)
    );

    // Choose the unit that owns this opcode and derive the write strobe.
    always_comb begin
        adder_class = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
                      (op == OP_SBB) || (op == OP_CMP) || (op == OP_DAA);
        result      = adder_class ? ar_res : lg_res;
        nx_flg      = adder_class ? ar_flg : lg_flg;
        result_we   = !((op == OP_CMP) || (op == OP_STC) || (op == OP_CMC));
    end

    // Flag register: cleared by reset, loaded on an execute strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (exec_en)
            flags_q <= nx_flg;
    end

    acc_alu_cond u_cond (
        .tested ({flags_q.p, flags_q.s, flags_q.z, flags_q.cy}),
        .sel    (cond_sel),
        .hit    (cond_true)
    );

    assign flags_next = nx_flg;
    assign flags      = flags_q;

endmodule

// File: rtl/acc_alu_chk.sv
// Property checker for acc_alu, attached by bind. Observes ports only.
// Flag bits: 4 S, 3 Z, 2 AC, 1 P, 0 CY.
module acc_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exec_en,
    input logic [3:0] opcode,
    input logic [7:0] acc_in,
    input logic [7:0] operand,
    input logic [2:0] cond_sel,
    input logic [7:0] result,
    input logic       result_we,
    input logic [4:0] flags_next,
    input logic [4:0] flags,
    input logic       cond_true
);

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(flags));

    assert_flag_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> (flags == $past(flags_next)));

    assert_cmp_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd7) |-> (!result_we && (flags_next[3] == (acc_in == operand))
                              && (flags_next[0] == (acc_in < operand))));

    assert_logic_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode inside {4'd4, 4'd5, 4'd6}) |->
            (!flags_next[0] && (flags_next[2] == (opcode == 4'd4))));

    assert_cma_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd13) |-> ((flags_next == flags) && (result == ~acc_in)));

    assert_stc_only_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd14) |-> (flags_next[0] && (flags_next[4:1] == flags[4:1])));

    assert_rlc_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd8) |-> ((flags_next[0] == acc_in[7]) && (result[0] == acc_in[7])));

    assert_cond_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd3) |-> (cond_true == flags[3]));

endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_en    (exec_en),
    .opcode     (opcode),
    .acc_in     (acc_in),
    .operand    (operand),
    .cond_sel   (cond_sel),
    .result     (result),
    .result_we  (result_we),
    .flags_next (flags_next),
    .flags      (flags),
    .cond_true  (cond_true)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/100ps
// Exhaustive operand sweeps against an arithmetic model of the requirements.
module acc_alu_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] operand = 8'd0;
    logic [2:0] cond_sel = 3'd0;
    logic [7:0] result;
    logic       result_we;
    logic [4:0] flags_next;
    logic [4:0] flags;
    logic       cond_true;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic done     = 1'b0;
    logic [4:0] mflags = 5'd0;

    always #5 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
        .acc_in(acc_in), .operand(operand), .cond_sel(cond_sel),
        .result(result), .result_we(result_we), .flags_next(flags_next),
        .flags(flags), .cond_true(cond_true)
    );

    // Expected {we, flags[4:0], result[7:0]}; flags = {S,Z,AC,P,CY}.
    function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [4:0] f);
        int ci; int t; int t2; int lo; logic lofix; logic hifix;
        logic [7:0] r; logic s, z, ac, p, cy, we, szp;
        s = f[4]; z = f[3]; ac = f[2]; p = f[1]; cy = f[0];
        r = a; we = 1'b1; szp = 1'b1;
        case (op)
            4'd0, 4'd1: begin
                ci = (op == 4'd1) ? int'(f[0]) : 0;
                t  = int'(a) + int'(b) + ci;
                r  = 8'(t); cy = (t > 255);
                ac = ((int'(a) % 16) + (int'(b) % 16) + ci) > 15;
            end
            4'd2, 4'd3, 4'd7: begin
                ci = (op == 4'd3) ? int'(f[0]) : 0;
                t  = int'(a) - int'(b) - ci;
                r  = 8'(t); cy = (t < 0);
                ac = ((int'(a) % 16) - (int'(b) % 16) - ci) < 0;
                we = (op != 4'd7);
            end
            4'd4: begin r = a & b; ac = 1'b1; cy = 1'b0; end
            4'd5: begin r = a ^ b; ac = 1'b0; cy = 1'b0; end
            4'd6: begin r = a | b; ac = 1'b0; cy = 1'b0; end
            4'd8:  begin r = {a[6:0], a[7]}; cy = a[7]; szp = 1'b0; end
            4'd9:  begin r = {a[0], a[7:1]}; cy = a[0]; szp = 1'b0; end
            4'd10: begin r = {a[6:0], f[0]}; cy = a[7]; szp = 1'b0; end
            4'd11: begin r = {f[0], a[7:1]}; cy = a[0]; szp = 1'b0; end
            4'd12: begin
                lo    = int'(a) % 16;
                lofix = (lo > 9) || f[2];
                ac    = lofix && (lo + 6 > 15);
                t     = int'(a) + (lofix ? 6 : 0);
                hifix = f[0] || (t > 255) || (((t / 16) % 16) > 9);
                t2    = (t % 256) + (hifix ? 96 : 0);
                r     = 8'(t2); cy = hifix;
            end
            4'd13: begin r = ~a; szp = 1'b0; end
            4'd14: begin cy = 1'b1; we = 1'b0; szp = 1'b0; end
            default: begin cy = ~f[0]; we = 1'b0; szp = 1'b0; end
        endcase
        if (szp) begin
            s = r[7]; z = (r == 8'd0); p = ~^r;
        end
        return {we, s, z, ac, p, cy, r};
    endfunction

    function automatic logic cond_exp(input logic [2:0] sel, input logic [4:0] f);
        case (sel)
            3'd0: return !f[0];
            3'd1: return  f[0];
            3'd2: return !f[3];
            3'd3: return  f[3];
            3'd4: return !f[4];
            3'd5: return  f[4];
            3'd6: return !f[1];
            default: return f[1];
        endcase
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:        return "R1";
            4'd2, 4'd3:        return "R2";
            4'd7:              return "R3";
            4'd4, 4'd5, 4'd6:  return "R4";
            4'd13:             return "R5";
            4'd14, 4'd15:      return "R6";
            4'd8, 4'd9:        return "R7";
            4'd10, 4'd11:      return "R8";
            default:           return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (op %0d acc %h opd %h flags %b)",
                     tag, act, exp, opcode, acc_in, operand, flags);
        end
    endtask

    // Apply one combinational vector and compare result, flags and write strobe.
    task automatic vec(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [13:0] e;
        opcode = op; acc_in = a; operand = b;
        #0.1;
        e = model(op, a, b, mflags);
        check(op_tag(op), {19'd0, flags_next, result}, {19'd0, e[12:0]});
        check("R12", {31'd0, result_we}, {31'd0, e[13]});
    endtask

    task automatic check_conds();
        for (int s = 0; s < 8; s++) begin
            cond_sel = 3'(s);
            #0.1;
            check("R11", {31'd0, cond_true}, {31'd0, cond_exp(3'(s), mflags)});
        end
    endtask

    // Execute one operation through the flag register and verify the load.
    task automatic exec_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [13:0] e;
        @(negedge clk);
        opcode = op; acc_in = a; operand = b; exec_en = 1'b1;
        e = model(op, a, b, mflags);
        @(posedge clk);
        #1;
        exec_en = 1'b0;
        mflags = e[12:8];
        check("R10", {27'd0, flags}, {27'd0, mflags});
        check_conds();
    endtask

    task automatic sweep_unary();
        for (int op = 8; op < 16; op++)
            for (int a = 0; a < 256; a++)
                vec(4'(op), 8'(a), 8'(a ^ 8'h5A));
    endtask

    task automatic sweep_binary();
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    vec(4'(op), 8'(a), 8'(b));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        mflags = 5'd0;
        check("R10", {27'd0, flags}, 32'd0);     // reset state
        check_conds();                            // R11 on cleared flags
        @(negedge clk);
        rst_n = 1'b1;

        // State: all flags clear (CY=0, AC=0).
        sweep_binary();
        sweep_unary();

        // State: CY=1 only.
        exec_op(4'd14, 8'h00, 8'h00);
        sweep_binary();
        sweep_unary();

        // Hold check R10: CMC with exec_en low must not change the register.
        @(negedge clk);
        opcode = 4'd15; exec_en = 1'b0;
        @(posedge clk);
        #1;
        check("R10", {27'd0, flags}, {27'd0, mflags});

        // State: AND of zero -> Z=1, AC=1, P=1, CY=0 (R13 zero/parity).
        exec_op(4'd4, 8'h00, 8'hFF);
        sweep_unary();

        // State: AC=1, CY=1.
        exec_op(4'd14, 8'h00, 8'h00);
        sweep_binary();
        sweep_unary();

        // State: 00-01 -> S=1, P=1 (eight ones), AC=1, CY=1, then CMC.
        exec_op(4'd2, 8'h00, 8'h01);
        exec_op(4'd15, 8'h00, 8'h00);
        sweep_unary();

        // R13: odd-parity, non-zero result through the register.
        exec_op(4'd6, 8'h07, 8'h00);
        // R9: classic BCD add 38h+45h then adjust gives 83h.
        exec_op(4'd0, 8'h38, 8'h45);
        exec_op(4'd12, 8'h7D, 8'h00);

        // R10: synchronous reset clears the register mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        mflags = 5'd0;
        check("R10", {27'd0, flags}, 32'd0);
        check_conds();
        rst_n = 1'b1;

        finish_run();
    end

endmodule